// File: doc/BRIEF.md
# Read-Snooping Data Termination Control

This block lives inside a DRAM device model or beside a rank in a memory controller. On every rising clock edge it watches the row strobe, column strobe and write enable lines of the shared command bus. It recognises READ commands on that bus no matter which rank they address. For each READ it takes the CAS latency and burst length that apply at that moment, and it switches off the on-die termination of the data group for a set window that starts a fixed number of clocks later. The data group is the data, read strobe, write strobe and mask pins.

The window opens CL−1 clocks after the READ is registered. It stays open for half the burst length plus two clocks. READs that come close together can have windows that overlap or touch, and these windows join, so termination stays off until the latest window closes. A force-off input, driven from the extended mode register, holds the data group unterminated for as long as it is high. Termination on all other pins is reported as permanently on.

The block has no chip-select input. In a two-rank system both devices therefore turn their data termination off for a READ sent to either of them.

Top module: `odt_read_snoop`

## Requirements
- R1: A READ is the bus pattern ras_n=1, cas_n=0, we_n=1 sampled on a rising clock edge. Every other pattern leaves the termination untouched, including write (1,0,0), activate (0,1,1), precharge (0,1,0), refresh (0,0,1), mode set (0,0,0) and idle (1,1,1). There is no chip-select input, so READs addressed to any rank are snooped.
- R2: For a READ registered at edge n with latency CL, dq_term_en goes low right after edge n+CL−1.
- R3: The off window lasts BL/2+2 clocks: 4 clocks when burst8=0 (BL4) and 6 clocks when burst8=1 (BL8). dq_term_en returns high right after edge n+CL−1+window.
- R4: cas_lat carries the latency in clocks and is valid from 5 to 11. A value below 5 is treated as 5 and a value above 11 is treated as 11.
- R5: CL and burst length are captured at the READ. Changing cas_lat or burst8 afterwards does not move a window that is already scheduled.
- R6: Windows that overlap or abut merge, with no high cycle between them. This holds even when a later READ with a shorter latency finishes before an earlier READ starts.
- R7: While data_term_off is high, dq_term_en is low. Scheduled windows keep running underneath and take effect again once data_term_off falls.
- R8: misc_term_en is always 1.
- R9: rst_n is an asynchronous active-low reset. It cancels all scheduled windows, so dq_term_en equals !data_term_off during reset and after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe of the command bus |
| cas_n | input | 1 | Column strobe of the command bus |
| we_n | input | 1 | Write enable of the command bus |
| cas_lat | input | CLW | CAS latency in clocks (5 to 11) |
| burst8 | input | 1 | 1 = burst length 8, 0 = burst length 4 |
| data_term_off | input | 1 | Force data-group termination off |
| dq_term_en | output | 1 | Termination enable for the data group |
| misc_term_en | output | 1 | Termination enable for all other pins |

## Verification
A table sweeps single isolated READs over both burst lengths, the latency extremes, a middle latency, and latencies outside the valid range. This separates start-delay errors from window-length errors and shows whether clamping is applied. Directed sequences then cover the following cases:
- READs two clocks apart, whose windows overlap.
- READs exactly one window apart, whose windows abut.
- A long-latency READ followed by a short-latency one, which shows whether windows merge in any order.
- Non-READ bus patterns.
- A mode change right after a READ.
- A force-off pulse that covers part of a window.
- A reset while a window is pending.

// File: rtl/odt_read_snoop.sv
module odt_read_snoop #(
  parameter int CL_MIN = 5,
  parameter int CL_MAX = 11,
  parameter int CLW    = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ras_n,
  input  logic           cas_n,
  input  logic           we_n,
  input  logic [CLW-1:0] cas_lat,
  input  logic           burst8,
  input  logic           data_term_off,
  output logic           dq_term_en,
  output logic           misc_term_en
);
  localparam int WIN_SHORT = 4;
  localparam int WIN_LONG  = 6;
  localparam int DEPTH     = CL_MAX - 2 + WIN_LONG;

  logic             rd_hit;
  logic [DEPTH-1:0] sched;
  logic [DEPTH-1:0] add_mask;
  logic             off_q;
  int               lat;
  int               win;

  assign rd_hit = ras_n & ~cas_n & we_n;

  always_comb begin
    lat = int'(cas_lat);
    if (lat < CL_MIN) lat = CL_MIN;
    if (lat > CL_MAX) lat = CL_MAX;
    win = burst8 ? WIN_LONG : WIN_SHORT;
    for (int j = 0; j < DEPTH; j++)
      add_mask[j] = rd_hit && (j >= lat - 2) && (j < lat - 2 + win);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sched <= '0;
      off_q <= 1'b0;
    end else begin
      sched <= {1'b0, sched[DEPTH-1:1]} | add_mask;
      off_q <= sched[0];
    end
  end

  assign dq_term_en   = ~off_q & ~data_term_off;
  assign misc_term_en = 1'b1;
endmodule

// File: rtl/odt_read_snoop_chk.sv
module odt_read_snoop_chk #(
  parameter int CL_MAX = 11
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic data_term_off,
  input logic dq_term_en,
  input logic misc_term_en
);
  localparam int REACH = CL_MAX - 2 + 6;

  logic [4:0] since_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rd <= 5'd31;
    else if (ras_n && !cas_n && we_n) since_rd <= 5'd0;
    else if (since_rd != 5'd31) since_rd <= since_rd + 5'd1;
  end

  a_r8_misc_on: assert property (@(posedge clk) disable iff (!rst_n)
    misc_term_en);

  a_r7_force_low: assert property (@(posedge clk) disable iff (!rst_n)
    data_term_off |-> !dq_term_en);

  a_r2_off_near_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!dq_term_en && !data_term_off) |-> (int'(since_rd) <= REACH));

  a_r3_min_len: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dq_term_en) && !data_term_off && $past(!data_term_off)) |=>
      (!dq_term_en || data_term_off));

  a_r9_reset_state: assert property (@(posedge clk)
    !rst_n |-> (dq_term_en == !data_term_off));
endmodule

bind odt_read_snoop odt_read_snoop_chk #(.CL_MAX(CL_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .data_term_off(data_term_off), .dq_term_en(dq_term_en),
  .misc_term_en(misc_term_en)
);

// File: tb/odt_read_snoop_test.sv
module odt_read_snoop_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [3:0] cas_lat = 4'd5;
  logic       burst8 = 1'b0;
  logic       data_term_off = 1'b0;
  logic       dq_term_en, misc_term_en;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit exp_off [0:2047];

  // fields: cas_lat[4:1], burst8[0]
  localparam int NVEC = 8;
  localparam logic [4:0] VEC [NVEC] = '{
    {4'd5, 1'b0}, {4'd5, 1'b1}, {4'd11, 1'b0}, {4'd11, 1'b1},
    {4'd8, 1'b1}, {4'd3, 1'b0}, {4'd15, 1'b1}, {4'd7, 1'b0}
  };

  odt_read_snoop uut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .cas_lat(cas_lat), .burst8(burst8), .data_term_off(data_term_off),
    .dq_term_en(dq_term_en), .misc_term_en(misc_term_en)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic act, input logic expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s: cycle %0d actual=%0b expected=%0b", tag, cyc, act, expv);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    cyc++;
    #2;
    check(tag, dq_term_en, !(exp_off[cyc] || data_term_off));
    check("R8 misc_term_en", misc_term_en, 1'b1);
    ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic mark(input int e, input int cl, input bit b8);
    int ce = (cl < 5) ? 5 : (cl > 11) ? 11 : cl;
    int w = b8 ? 6 : 4;
    for (int k = e + ce - 1; k <= e + ce - 2 + w; k++) exp_off[k] = 1'b1;
  endtask

  task automatic rd(input int cl, input bit b8, input string tag);
    ras_n = 1'b1; cas_n = 1'b0; we_n = 1'b1;
    cas_lat = 4'(cl); burst8 = b8;
    mark(cyc + 1, cl, b8);
    step(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic cmd(input logic r, input logic c, input logic w);
    ras_n = r; cas_n = c; we_n = w;
    step("R1 non-read pattern");
  endtask

  initial begin
    #1 rst_n = 1'b0;
    idle(3, "R9 reset state");
    rst_n = 1'b1;
    idle(2, "R9 after reset");

    for (int v = 0; v < NVEC; v++) begin
      rd(int'(VEC[v][4:1]), VEC[v][0], "R2 R3 R4 single read");
      idle(18, "R2 R3 R4 single read");
    end

    cmd(1'b1, 1'b0, 1'b0);
    cmd(1'b0, 1'b1, 1'b1);
    cmd(1'b0, 1'b1, 1'b0);
    cmd(1'b0, 1'b0, 1'b1);
    cmd(1'b0, 1'b0, 1'b0);
    idle(16, "R1 no read seen");

    rd(5, 1'b0, "R5 capture");
    cas_lat = 4'd11; burst8 = 1'b1;
    idle(18, "R5 later mode change ignored");

    rd(6, 1'b1, "R6 overlap");
    step("R6 overlap");
    rd(6, 1'b1, "R6 overlap");
    idle(20, "R6 overlap merge");

    rd(5, 1'b0, "R6 abut");
    idle(3, "R6 abut");
    rd(5, 1'b0, "R6 abut");
    idle(16, "R6 abut merge");

    rd(11, 1'b1, "R6 mixed");
    step("R6 mixed");
    rd(5, 1'b0, "R6 mixed");
    idle(20, "R6 mixed latency merge");

    rd(7, 1'b1, "R7 force");
    idle(3, "R7 force");
    data_term_off = 1'b1;
    idle(4, "R7 force holds low");
    data_term_off = 1'b0;
    idle(15, "R7 window resumes");
    data_term_off = 1'b1;
    idle(3, "R7 force while idle");
    data_term_off = 1'b0;
    step("R7 release");

    rd(11, 1'b1, "R9 reset pending");
    idle(5, "R9 reset pending");
    rst_n = 1'b0;
    for (int k = cyc; k < cyc + 40; k++) exp_off[k] = 1'b0;
    #1 check("R9 async reset", dq_term_en, 1'b1);
    idle(2, "R9 in reset");
    rst_n = 1'b1;
    idle(20, "R9 pending window cancelled");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule